// File: doc/BRIEF.md
# Write-Only Serial Configuration Receiver

This block is a receive-only slave on a two-wire serial bus. It loads a bank of eight 8-bit configuration registers. A fast system clock oversamples the clock and data lines. Each line passes through a synchroniser, and the block recognises bus start and stop conditions by the edges it sees on the sampled lines. Bytes arrive most significant bit first. After each byte it accepts, the block acknowledges by pulling the data line low.

A frame has a fixed layout: one address byte, two framing bytes, and then up to eight data bytes. The framing bytes are acknowledged and their values are thrown away. The data bytes fill registers 0 through 7 in order. If the address is wrong, the block stays silent for the rest of the frame. Registers leave reset with fixed default values, so the surrounding logic can run with no serial access at all. Each register update also produces a one-cycle strobe together with the index of the register that changed.

Top module: `cfg_serial_rx`

## Requirements
- R1: After reset, register i holds byte i of the package constant CFGRX_RESET (bits 8*i+7 down to 8*i), and the data line is released.
- R2: Bytes are taken only after a start condition, which is the data line falling while the clock line is high. Clock pulses sent with no start, or after a stop (the data line rising while the clock is high), change no register, produce no strobe and produce no acknowledge.
- R3: The first byte after a start must equal 8'hD2. For any other value, the rest of the frame produces no acknowledge, no strobe and no register change.
- R4: For every accepted byte, the block pulls the data line low while the clock is high during the ninth clock pulse. Accepted bytes are the matching address, the two framing bytes and up to eight data bytes.
- R5: The second and third bytes of a matching frame are acknowledged. Their values have no effect on any register.
- R6: Bytes 4 to 11 of a matching frame are written, most significant bit first, into registers 0 to 7 in that order.
- R7: Each register write raises the update strobe for exactly one system cycle while the clock line is still high during that byte's eighth bit. The update index equals the register number during that cycle.
- R8: A stop before the eighth data byte ends the frame. Registers already written keep their new values. Later registers keep their old values.
- R9: A repeated start (a start condition with no stop before it) abandons the current frame and treats the next byte as a new address byte.
- R10: Bytes that follow the eighth data byte in the same frame are neither acknowledged nor written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as sampled from the bus |
| sda_i | input | 1 | Serial data line as sampled from the bus |
| sda_pull_o | output | 1 | 1 pulls the data line low (open-drain acknowledge) |
| cfg_o | output | 64 | Register bank, register i at bits 8*i+7:8*i |
| upd_stb_o | output | 1 | One-cycle pulse on each register write |
| upd_idx_o | output | 3 | Index of the register written when the strobe is high |

## Verification
The directed frames cover these cases:
- a complete matching frame, which checks the byte-to-register order and the acknowledges;
- an address of 8'hD3, with the read bit set, which checks that the frame is dropped;
- a stop after three data bytes, which separates written registers from untouched ones;
- a repeated start in the middle of a frame;
- a frame with twelve data bytes, which checks that bytes past the bank are ignored;
- bytes clocked with no start at all.

Random frames then mix matching and random addresses, random framing-byte values, lengths from zero to ten data bytes, and endings by stop or by repeated start. After every frame, a bench model supplies the expected register contents, acknowledge pattern and strobe sequence, which catches any mix-up between the framing bytes and the data slots.

// File: rtl/cfgrx_pkg.sv
package cfgrx_pkg;

    localparam int unsigned CFGRX_NREG  = 8;
    localparam int unsigned CFGRX_REGW  = 8;
    localparam logic [7:0]  CFGRX_ADDR  = 8'hD2;
    localparam logic [CFGRX_NREG*CFGRX_REGW-1:0] CFGRX_RESET = 64'h0F00_FFFF_7E3C_A55A;

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_ADDR,
        FR_CMD,
        FR_CNT,
        FR_DATA,
        FR_SKIP
    } frame_st_t;

    function automatic logic addr_hit(input logic [7:0] b);
        return b == CFGRX_ADDR;
    endfunction

endpackage

// File: rtl/cfgrx_bus_sync.sv
module cfgrx_bus_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    localparam int unsigned NLINE = 2;

    logic [NLINE-1:0] raw;
    logic [NLINE-1:0] cur;
    logic [NLINE-1:0] prev;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < NLINE; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain   <= '1;
                prev[g] <= 1'b1;
            end else begin
                chain   <= {chain[STAGES-2:0], raw[g]};
                prev[g] <= chain[STAGES-1];
            end
        end
        assign cur[g] = chain[STAGES-1];
    end

    always_comb begin
        sda_lvl   = cur[1];
        scl_rise  = cur[0] & ~prev[0];
        scl_fall  = ~cur[0] & prev[0];
        bus_start = cur[0] & prev[0] & prev[1] & ~cur[1];
        bus_stop  = cur[0] & prev[0] & ~prev[1] & cur[1];
    end

endmodule

// File: rtl/cfgrx_byte_rx.sv
module cfgrx_byte_rx #(
    parameter int unsigned BITS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sda_lvl,
    input  logic            scl_rise,
    input  logic            scl_fall,
    input  logic            bus_start,
    input  logic            bus_stop,
    input  logic            ack_ok,
    output logic            byte_done,
    output logic [BITS-1:0] byte_val,
    output logic            sda_pull
);
    localparam int unsigned CW = $clog2(BITS + 1);
    localparam logic [CW-1:0] FULL = CW'(BITS);
    localparam logic [CW-1:0] LAST = CW'(BITS - 1);

    logic          active;
    logic [CW-1:0] bit_cnt;
    logic          ack_phase;

    always_ff @(posedge clk) begin
        if (rst || bus_stop) begin
            active    <= 1'b0;
            bit_cnt   <= '0;
            ack_phase <= 1'b0;
            sda_pull  <= 1'b0;
            byte_done <= 1'b0;
            if (rst) byte_val <= '0;
        end else if (bus_start) begin
            active    <= 1'b1;
            bit_cnt   <= '0;
            ack_phase <= 1'b0;
            sda_pull  <= 1'b0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (active) begin
                if (scl_rise && bit_cnt < FULL) begin
                    byte_val <= {byte_val[BITS-2:0], sda_lvl};
                    bit_cnt  <= bit_cnt + 1'b1;
                    if (bit_cnt == LAST) byte_done <= 1'b1;
                end else if (scl_fall && bit_cnt == FULL) begin
                    if (!ack_phase) begin
                        ack_phase <= 1'b1;
                        sda_pull  <= ack_ok;
                    end else begin
                        ack_phase <= 1'b0;
                        sda_pull  <= 1'b0;
                        bit_cnt   <= '0;
                    end
                end
            end
        end
    end

    // R4: the line is pulled only in the acknowledge slot
    p_pull_in_ack_r4: assert property (@(posedge clk) disable iff (rst)
        sda_pull |-> (bit_cnt == FULL && ack_phase));

    // R2: no byte completes without an open transaction
    p_done_needs_start_r2: assert property (@(posedge clk) disable iff (rst)
        byte_done |-> (active && bit_cnt == FULL));

    p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= FULL);

endmodule

// File: rtl/cfgrx_frame.sv
module cfgrx_frame
    import cfgrx_pkg::*;
#(
    parameter int unsigned NREG = CFGRX_NREG,
    parameter int unsigned REGW = CFGRX_REGW,
    parameter logic [NREG*REGW-1:0] RESET_VAL = CFGRX_RESET
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_start,
    input  logic                     bus_stop,
    input  logic                     byte_done,
    input  logic [REGW-1:0]          byte_val,
    output logic                     ack_ok,
    output logic [NREG*REGW-1:0]     regs_flat,
    output logic                     upd_stb,
    output logic [$clog2(NREG)-1:0]  upd_idx
);
    localparam int unsigned IW = $clog2(NREG);
    localparam logic [IW-1:0] LAST_IDX = IW'(NREG - 1);

    frame_st_t     st;
    logic [IW-1:0] idx;
    logic [REGW-1:0] bank [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= FR_IDLE;
            idx     <= '0;
            ack_ok  <= 1'b0;
            upd_stb <= 1'b0;
            upd_idx <= '0;
            for (int i = 0; i < NREG; i++) bank[i] <= RESET_VAL[i*REGW +: REGW];
        end else begin
            upd_stb <= 1'b0;
            if (bus_start) begin
                st     <= FR_ADDR;
                idx    <= '0;
                ack_ok <= 1'b0;
            end else if (bus_stop) begin
                st     <= FR_IDLE;
                ack_ok <= 1'b0;
            end else if (byte_done) begin
                case (st)
                    FR_ADDR: begin
                        if (addr_hit(byte_val)) begin
                            st     <= FR_CMD;
                            ack_ok <= 1'b1;
                        end else begin
                            st     <= FR_SKIP;
                            ack_ok <= 1'b0;
                        end
                    end
                    FR_CMD: begin
                        st     <= FR_CNT;
                        ack_ok <= 1'b1;
                    end
                    FR_CNT: begin
                        st     <= FR_DATA;
                        idx    <= '0;
                        ack_ok <= 1'b1;
                    end
                    FR_DATA: begin
                        bank[idx] <= byte_val;
                        upd_stb   <= 1'b1;
                        upd_idx   <= idx;
                        ack_ok    <= 1'b1;
                        if (idx == LAST_IDX) st <= FR_SKIP;
                        else                 idx <= idx + 1'b1;
                    end
                    default: ack_ok <= 1'b0;
                endcase
            end
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_out
        assign regs_flat[g*REGW +: REGW] = bank[g];
    end

    // R6: writes come only from the data phase
    p_write_in_data_r6: assert property (@(posedge clk) disable iff (rst)
        upd_stb |-> ($past(st) == FR_DATA));

    // R3 / R10: a dropped or finished frame writes nothing more
    p_skip_no_write_r3: assert property (@(posedge clk) disable iff (rst)
        (st == FR_SKIP) |=> !upd_stb);

    // R7: strobe lasts one cycle
    p_stb_single_r7: assert property (@(posedge clk) disable iff (rst)
        upd_stb |=> !upd_stb);

    // R8: the bank moves only together with a strobe
    p_bank_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !upd_stb |-> $stable(regs_flat));

endmodule

// File: rtl/cfg_serial_rx.sv
module cfg_serial_rx
    import cfgrx_pkg::*;
#(
    parameter int unsigned NREG = CFGRX_NREG,
    parameter int unsigned REGW = CFGRX_REGW,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [NREG*REGW-1:0] RESET_VAL = CFGRX_RESET
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    scl_i,
    input  logic                    sda_i,
    output logic                    sda_pull_o,
    output logic [NREG*REGW-1:0]    cfg_o,
    output logic                    upd_stb_o,
    output logic [$clog2(NREG)-1:0] upd_idx_o
);
    logic            sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
    logic            byte_done, ack_ok;
    logic [REGW-1:0] byte_val;

    cfgrx_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    cfgrx_byte_rx #(.BITS(REGW)) u_byte (
        .clk       (clk),
        .rst       (rst),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .ack_ok    (ack_ok),
        .byte_done (byte_done),
        .byte_val  (byte_val),
        .sda_pull  (sda_pull_o)
    );

    cfgrx_frame #(.NREG(NREG), .REGW(REGW), .RESET_VAL(RESET_VAL)) u_frame (
        .clk       (clk),
        .rst       (rst),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .byte_done (byte_done),
        .byte_val  (byte_val),
        .ack_ok    (ack_ok),
        .regs_flat (cfg_o),
        .upd_stb   (upd_stb_o),
        .upd_idx   (upd_idx_o)
    );

endmodule

// File: tb/test_cfg_serial_rx.sv
module test_cfg_serial_rx;
    import cfgrx_pkg::*;

    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull;
    logic [63:0] cfg;
    logic upd_stb;
    logic [2:0] upd_idx;
    wire  sda_line = sda_m & ~sda_pull;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [7:0] model [8];
    logic [7:0] dat [12];
    int  stb_seen = 0;
    bit  bus_busy = 0;
    bit  prev_stb = 0;

    always #5 clk = ~clk;

    cfg_serial_rx i_cfg_serial_rx (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull),
        .cfg_o      (cfg),
        .upd_stb_o  (upd_stb),
        .upd_idx_o  (upd_idx)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] model_flat();
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[i*8 +: 8] = model[i];
        return v;
    endfunction

    // strobe monitor (R7)
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (upd_stb) begin
                chk(scl_m == 1'b1, "R7", "strobe outside clock-high", 64'(scl_m), 64'd1);
                chk(upd_idx == 3'(stb_seen), "R7", "strobe index", 64'(upd_idx), 64'(stb_seen));
                chk(!prev_stb, "R7", "strobe longer than one cycle", 64'd2, 64'd1);
                stb_seen++;
            end
            prev_stb = upd_stb;
        end
    end

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start_c();
        sda_m = 1'b0; wclk(Q);
        scl_m = 1'b0; wclk(Q);
    endtask

    task automatic bus_rstart_c();
        sda_m = 1'b1; wclk(Q);
        scl_m = 1'b1; wclk(Q);
        sda_m = 1'b0; wclk(Q);
        scl_m = 1'b0; wclk(Q);
    endtask

    task automatic bus_stop_c();
        sda_m = 1'b0; wclk(Q);
        scl_m = 1'b1; wclk(Q);
        sda_m = 1'b1; wclk(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int k = 7; k >= 0; k--) begin
            sda_m = b[k]; wclk(Q);
            scl_m = 1'b1; wclk(Q);
            scl_m = 1'b0; wclk(Q);
        end
        sda_m = 1'b1; wclk(Q);
        scl_m = 1'b1; wclk(Q/2);
        acked = (sda_line == 1'b0);
        wclk(Q/2);
        scl_m = 1'b0; wclk(Q);
    endtask

    // one frame: address, two framing bytes, ndata data bytes from dat[]
    task automatic frame(input logic [7:0] addr, input int ndata, input bit rep,
                         input string req);
        bit match = (addr == 8'hD2);
        bit a;
        int nw;
        logic [15:0] ack_got = '0, ack_exp = '0;
        stb_seen = 0;
        if (!bus_busy) bus_start_c();
        for (int k = 0; k < ndata + 3; k++) begin
            logic [7:0] b;
            if (k == 0) b = addr;
            else if (k < 3) b = 8'($urandom);
            else b = dat[k-3];
            send_byte(b, a);
            ack_got[k] = a;
            ack_exp[k] = match && (k < 11);
        end
        if (rep) begin bus_rstart_c(); bus_busy = 1; end
        else begin bus_stop_c(); bus_busy = 0; end
        nw = match ? ((ndata < 8) ? ndata : 8) : 0;
        for (int i = 0; i < nw; i++) model[i] = dat[i];
        chk(ack_got == ack_exp, req, "acknowledge pattern", 64'(ack_got), 64'(ack_exp));
        chk(stb_seen == nw, req, "strobe count", 64'(stb_seen), 64'(nw));
        chk(cfg == model_flat(), req, "register bank", cfg, model_flat());
    endtask

    initial begin
        bit a;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 8; i++) model[i] = CFGRX_RESET[i*8 +: 8];
        wclk(4);
        rst = 1'b0;
        wclk(4);
        // R1 reset state
        chk(cfg == CFGRX_RESET, "R1", "reset bank", cfg, CFGRX_RESET);
        chk(sda_pull == 1'b0, "R1", "line released", 64'(sda_pull), 64'd0);

        // R2: bytes with no start condition
        stb_seen = 0;
        scl_m = 1'b0; wclk(Q);
        send_byte(8'hD2, a);
        chk(!a, "R2", "ack without start", 64'(a), 64'd0);
        send_byte(8'h00, a);
        send_byte(8'h00, a);
        send_byte(8'h99, a);
        chk(!a, "R2", "ack on data without start", 64'(a), 64'd0);
        sda_m = 1'b1; wclk(Q); scl_m = 1'b1; wclk(Q);
        chk(stb_seen == 0, "R2", "strobe without start", 64'(stb_seen), 64'd0);
        chk(cfg == model_flat(), "R2", "bank after no-start bytes", cfg, model_flat());

        // R6 / R5 / R4: full matching frame
        for (int i = 0; i < 8; i++) dat[i] = 8'h11 * 8'(i + 1) ^ 8'h80;
        frame(8'hD2, 8, 0, "R6");

        // R3: address with read bit set
        for (int i = 0; i < 8; i++) dat[i] = 8'hC0 | 8'(i);
        frame(8'hD3, 8, 0, "R3");

        // R8: stop after three data bytes
        for (int i = 0; i < 8; i++) dat[i] = 8'h5A + 8'(i);
        frame(8'hD2, 3, 0, "R8");

        // R9: repeated start after two data bytes, then a fresh frame
        for (int i = 0; i < 8; i++) dat[i] = 8'hE1 ^ 8'(i * 3);
        frame(8'hD2, 2, 1, "R9");
        for (int i = 0; i < 8; i++) dat[i] = 8'h0F + 8'(i * 7);
        frame(8'hD2, 5, 0, "R9");

        // R10: twelve data bytes, last four ignored
        for (int i = 0; i < 12; i++) dat[i] = 8'(8'h20 + i * 9);
        frame(8'hD2, 12, 0, "R10");

        // R5: framing byte values irrelevant; random frames
        for (int t = 0; t < 18; t++) begin
            logic [7:0] ad = ($urandom % 3 == 0) ? 8'($urandom) : 8'hD2;
            int n = $urandom % 11;
            for (int i = 0; i < 12; i++) dat[i] = 8'($urandom);
            frame(ad, n, 1'($urandom % 2), "R5");
        end
        if (bus_busy) begin bus_stop_c(); bus_busy = 0; end
        wclk(Q);
        chk(cfg == model_flat(), "R8", "final bank", cfg, model_flat());

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule